// File: doc/BRIEF.md
# Tag RAM BIST Port Adapter

This block sits between a memory self-test controller and the per-way tag RAMs of a cache controller, at most eight of them. During a test the controller addresses one tag RAM at a time. The adapter sends each chip-enable bit to its RAM. It cuts the RAM index out of the test address. It also rearranges the test write data so that the parity bit becomes the lowest bit of the tag word.

On the read side, the test controller raises one read-control bit per RAM in the cycle when that RAM's output data is valid. The adapter captures the selected word and maps it back into test-data order. It returns the word through a fixed path of two registers.

The cache size is a parameter, and it sets both the index width and the tag width. The RAM read latency is a parameter from 1 to 8 cycles. The adapter's logic does not depend on the latency. The latency only tells the test controller, and the timing check, when read data is valid.

Top module: `tag_bist_bridge`

## Requirements
- R1: Tag RAM select `tag_cs[i]` equals `bist_ce[i+1]` for every way i. Bit 0 of `bist_ce` has no effect.
- R2: `tag_addr` equals `bist_addr[IDX_W+1:2]`, where IDX_W = log2(CACHE_KB)+2 (9 bits for 128KB up to 13 bits for 2MB). All other address bits have no effect.
- R3: `tag_wd` is TAG_W = 29-IDX_W bits wide. Its bit 0 is `bist_din[19]`, the parity bit. Its bits TAG_W-1:1 are `bist_din[18:20-TAG_W]`. All other data-in bits have no effect.
- R4: `tag_we` follows `bist_we` combinationally.
- R5: When exactly one read-control bit `bist_dctl[3+w]` is high, the output word of tag RAM w is captured on that clock edge. The captured word appears on `bist_dout` one clock edge later, remapped as follows:
  - `bist_dout[19]` carries tag bit 0.
  - `bist_dout[18:20-TAG_W]` carries tag bits TAG_W-1:1.
  - All other output bits are 0.
  - As a result, a word written and read back returns `bist_din[19:20-TAG_W]` in the same bit positions.
- R6: When no bit of `bist_dctl[3+NUM_WAYS-1:3]` is high, the capture register holds its value, so `bist_dout` does not change.
- R7: When two or more read-control bits are high at a clock edge, the capture register loads zero, so `bist_dout` becomes 0 one edge later. `proto_err` rises on that same edge and stays high until reset.
- R8: `bist_dctl[2:0]` has no effect on capture or on `bist_dout`.
- R9: After reset, `bist_dout` is 0 and `proto_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bist_ce | input | NUM_WAYS+1 | Test chip enables; bits NUM_WAYS:1 select the ways |
| bist_we | input | 1 | Test write strobe |
| bist_addr | input | ADDR_W | Test address |
| bist_din | input | BIST_DW | Test write data; bits 19:0 used |
| bist_dctl | input | NUM_WAYS+3 | Read controls; bit 3+w selects way w |
| tag_rd | input | NUM_WAYS*TAG_W | Output data of all tag RAMs, way 0 in the low bits |
| tag_cs | output | NUM_WAYS | Tag RAM selects |
| tag_we | output | 1 | Tag RAM write enable |
| tag_addr | output | IDX_W | Tag RAM index |
| tag_wd | output | TAG_W | Tag RAM write word |
| bist_dout | output | BIST_DW | Registered, remapped read data |
| proto_err | output | 1 | Sticky flag: more than one read control was high |

## Verification
The assertions check the following on every cycle:
- at most one tag RAM is selected;
- the capture register holds when no read control is high and clears when several are high;
- the error flag stays high once set;
- a sole read control always has a read of the same way exactly RD_LAT cycles before it;
- each way's data lands in the capture register.

Only the bench scenarios can show the following: the exact bit remapping in both directions at each port, that the ignored address, data and control bits truly have no effect, and the full write-then-read round trip through a RAM model with several-cycle latency.

// File: rtl/tag_bist_bridge.sv
module tag_bist_bridge #(
  parameter int CACHE_KB = 128,
  parameter int NUM_WAYS = 8,
  parameter int RD_LAT   = 1,
  parameter int ADDR_W   = 16,
  parameter int BIST_DW  = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_WAYS:0]            bist_ce,
  input  logic                         bist_we,
  input  logic [ADDR_W-1:0]            bist_addr,
  input  logic [BIST_DW-1:0]           bist_din,
  input  logic [NUM_WAYS+2:0]          bist_dctl,
  input  logic [NUM_WAYS*(27-$clog2(CACHE_KB))-1:0] tag_rd,
  output logic [NUM_WAYS-1:0]          tag_cs,
  output logic                         tag_we,
  output logic [$clog2(CACHE_KB)+1:0]  tag_addr,
  output logic [26-$clog2(CACHE_KB):0] tag_wd,
  output logic [BIST_DW-1:0]           bist_dout,
  output logic                         proto_err
);

  localparam int IDX_W = $clog2(CACHE_KB) + 2;
  localparam int TAG_W = 29 - IDX_W;
  localparam int PAD_W = 20 - TAG_W;
  localparam logic [ADDR_W-1:0]  ADDR_MASK = ADDR_W'(((1 << IDX_W) - 1) << 2);
  localparam logic [BIST_DW-1:0] DIN_MASK  = BIST_DW'((20'hFFFFF >> PAD_W) << PAD_W);

  logic [NUM_WAYS-1:0] sel;
  logic                multi;
  logic [TAG_W-1:0]    sel_word;
  logic [TAG_W-1:0]    cap_q;
  logic [BIST_DW-1:0]  remap;
  logic                unused_bits;

  assign tag_cs   = bist_ce[NUM_WAYS:1];
  assign tag_we   = bist_we;
  assign tag_addr = bist_addr[IDX_W+1:2];
  assign tag_wd   = {bist_din[18:PAD_W], bist_din[19]};

  assign unused_bits = bist_ce[0] ^ (^(bist_addr & ~ADDR_MASK)) ^
                       (^(bist_din & ~DIN_MASK)) ^ (^bist_dctl[2:0]);

  assign sel   = bist_dctl[NUM_WAYS+2:3];
  assign multi = |(sel & (sel - NUM_WAYS'(1)));

  always_comb begin
    sel_word = '0;
    for (int w = 0; w < NUM_WAYS; w++)
      sel_word |= tag_rd[w*TAG_W +: TAG_W] & {TAG_W{sel[w]}};
  end

  always_comb begin
    remap = '0;
    remap[19] = cap_q[0];
    remap[18:PAD_W] = cap_q[TAG_W-1:1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q     <= '0;
      bist_dout <= '0;
      proto_err <= 1'b0;
    end else begin
      if (multi) begin
        cap_q     <= '0;
        proto_err <= 1'b1;
      end else if (|sel) begin
        cap_q <= sel_word;
      end
      bist_dout <= remap;
    end
  end

  logic [NUM_WAYS-1:0] rd_hist [RD_LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RD_LAT; i++) rd_hist[i] <= '0;
    end else begin
      rd_hist[0] <= tag_cs & {NUM_WAYS{~tag_we}};
      for (int i = 1; i < RD_LAT; i++) rd_hist[i] <= rd_hist[i-1];
    end
  end

  // R1
  ce_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tag_cs));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == '0) |=> $stable(cap_q));

  // R7
  multi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    multi |=> (cap_q == '0) && proto_err);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  // R5
  sel_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(sel) |-> |(sel & rd_hist[RD_LAT-1]));

  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_cap
    // R5
    way_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == NUM_WAYS'(1) << g) |=> cap_q == $past(tag_rd[g*TAG_W +: TAG_W]));
  end

endmodule

// File: tb/tag_bist_bridge_tb.sv
module tag_bist_bridge_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CKB = 512;
  localparam int LAT = 3;
  localparam int W   = 8;
  localparam int IDX = 11;
  localparam int TW  = 18;
  localparam int PAD = 2;
  localparam logic [31:0] RET_MASK = 32'h000F_FFFC;

  logic clk = 0, rst_n = 0;
  logic [W:0]      bist_ce = '0;
  logic            bist_we = 0;
  logic [15:0]     bist_addr = '0;
  logic [31:0]     bist_din = '0;
  logic [W+2:0]    bist_dctl = '0;
  logic [W*TW-1:0] tag_rd;
  logic [W-1:0]    tag_cs;
  logic            tag_we;
  logic [IDX-1:0]  tag_addr;
  logic [TW-1:0]   tag_wd;
  logic [31:0]     bist_dout;
  logic            proto_err;
  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tag_bist_bridge #(.CACHE_KB(CKB), .NUM_WAYS(W), .RD_LAT(LAT), .ADDR_W(16), .BIST_DW(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .bist_ce(bist_ce), .bist_we(bist_we), .bist_addr(bist_addr),
    .bist_din(bist_din), .bist_dctl(bist_dctl), .tag_rd(tag_rd), .tag_cs(tag_cs),
    .tag_we(tag_we), .tag_addr(tag_addr), .tag_wd(tag_wd), .bist_dout(bist_dout),
    .proto_err(proto_err));

  logic [TW-1:0] mem [int];
  logic [TW-1:0] pipe [W][LAT];

  always @(posedge clk) begin
    for (int w = 0; w < W; w++) begin
      for (int s = LAT-1; s > 0; s--) pipe[w][s] <= pipe[w][s-1];
      if (tag_cs[w] && !tag_we)
        pipe[w][0] <= mem.exists(w*8192 + int'(tag_addr)) ? mem[w*8192 + int'(tag_addr)] : '0;
      else
        pipe[w][0] <= '1;
      if (tag_cs[w] && tag_we) mem[w*8192 + int'(tag_addr)] = tag_wd;
    end
  end

  always_comb
    for (int w = 0; w < W; w++) tag_rd[w*TW +: TW] = pipe[w][LAT-1];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int way, input int idx, input logic [31:0] din);
    @(negedge clk);
    bist_ce = (W+1)'(1) << (way + 1); bist_we = 1;
    bist_addr = 16'(idx << 2); bist_din = din;
    @(negedge clk);
    bist_ce = '0; bist_we = 0;
  endtask

  task automatic rd(input int way, input int idx, input logic [31:0] exp, input string req);
    @(negedge clk);
    bist_ce = (W+1)'(1) << (way + 1); bist_we = 0; bist_addr = 16'(idx << 2);
    @(negedge clk);
    bist_ce = '0;
    repeat (LAT-1) @(negedge clk);
    bist_dctl = (W+3)'(1) << (way + 3);
    @(negedge clk);
    bist_dctl = '0;
    @(negedge clk);
    check(bist_dout == exp, req, bist_dout, exp);
  endtask

  task automatic t_reset();
    check(bist_dout == 32'h0, "R9 dout", bist_dout, 32'h0);
    check(proto_err == 1'b0, "R9 err", 32'(proto_err), 32'h0);
  endtask

  task automatic t_ce();
    for (int i = 0; i < W; i++) begin
      @(negedge clk); bist_ce = (W+1)'(1) << (i + 1);
      #1 check(tag_cs == W'(1) << i, "R1 steer", 32'(tag_cs), 32'(1 << i));
    end
    @(negedge clk); bist_ce = (W+1)'(1);
    #1 check(tag_cs == '0, "R1 bit0", 32'(tag_cs), 32'h0);
    @(negedge clk); bist_ce = '0;
  endtask

  task automatic t_addr();
    logic [IDX-1:0] first;
    bist_addr = 16'hA5F7;
    #1 check(tag_addr == IDX'(16'hA5F7 >> 2), "R2 index", 32'(tag_addr), 32'((16'hA5F7 >> 2) & 16'h7FF));
    first = tag_addr;
    bist_addr = 16'hA5F7 ^ 16'hE003;
    #1 check(tag_addr == first, "R2 ignored bits", 32'(tag_addr), 32'(first));
    bist_addr = 16'h0004;
    #1 check(tag_addr == IDX'(1), "R2 low index", 32'(tag_addr), 32'h1);
  endtask

  task automatic t_wdata();
    logic [31:0] d;
    logic [TW-1:0] e;
    d = 32'hFFF8_1235;
    bist_din = d; bist_we = 1;
    e = {d[18:PAD], d[19]};
    #1 check(tag_wd == e, "R3 parity low", 32'(tag_wd), 32'(e));
    check(tag_we == 1'b1, "R4 we high", 32'(tag_we), 32'h1);
    d = 32'h0007_5A5A ^ 32'hFFF0_0003;
    bist_din = d; bist_we = 0;
    e = {d[18:PAD], d[19]};
    #1 check(tag_wd == e, "R3 ignored bits", 32'(tag_wd), 32'(e));
    check(tag_we == 1'b0, "R4 we low", 32'(tag_we), 32'h0);
  endtask

  task automatic t_roundtrip();
    logic [31:0] v [W];
    for (int w = 0; w < W; w++) begin
      v[w] = 32'h9E37_79B9 * (w + 3);
      wr(w, 5, v[w]);
    end
    wr(3, 2047, 32'h0008_0001);
    wr(3, 0, 32'h0007_FFFC);
    for (int w = W-1; w >= 0; w--) rd(w, 5, v[w] & RET_MASK, "R5 way data");
    rd(3, 2047, 32'h0008_0000, "R5 parity only");
    rd(3, 0, 32'h0007_FFFC, "R5 top index bits");
  endtask

  task automatic t_hold();
    logic [31:0] prev;
    rd(6, 5, (32'h9E37_79B9 * 9) & RET_MASK, "R5 before hold");
    prev = bist_dout;
    @(negedge clk); bist_dctl = (W+3)'(3'b111);
    repeat (3) @(negedge clk);
    bist_dctl = '0;
    @(negedge clk);
    check(bist_dout == prev, "R8 low controls ignored", bist_dout, prev);
    @(negedge clk); bist_ce = (W+1)'(1) << 2;
    @(negedge clk); bist_ce = '0;
    repeat (LAT + 2) @(negedge clk);
    check(bist_dout == prev, "R6 no select holds", bist_dout, prev);
    check(proto_err == 1'b0, "R6 no error", 32'(proto_err), 32'h0);
  endtask

  task automatic t_multi();
    @(negedge clk); bist_dctl = (W+3)'(11'b00000101000);
    @(negedge clk); bist_dctl = '0;
    check(proto_err == 1'b1, "R7 err set", 32'(proto_err), 32'h1);
    @(negedge clk);
    check(bist_dout == 32'h0, "R7 zero data", bist_dout, 32'h0);
    rd(0, 5, (32'h9E37_79B9 * 3) & RET_MASK, "R7 later read ok");
    check(proto_err == 1'b1, "R7 err sticky", 32'(proto_err), 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ce();
    t_addr();
    t_wdata();
    t_roundtrip();
    t_hold();
    t_multi();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule